// File: doc/BRIEF.md
# Microsecond Timebase Counter

This block turns a reference clock into a 1 MHz event stream and a running microsecond count. The reference may run at any of several common crystal rates. A fractional divider handles rates that are not a whole multiple of 1 MHz. It adds a programmable numerator into an accumulator on every reference cycle. Whenever the accumulator reaches the programmed denominator, the divider issues a one-cycle tick and subtracts the denominator. Over any whole number of accumulator periods, the average tick rate is exactly numerator/denominator times the reference rate.

Each tick advances a free-running unsigned counter, which wraps at its full width. Software reads this counter through a small register port, and the same port sets the divider ratio. The tick output also drives other timers. A freeze control stops both the tick and the count, and the count resumes where it stopped when the freeze is cleared.

Top module: `usec_timebase`

## Requirements
- R1: After synchronous reset, the count reads 0, the divider setting reads 0x000b and the freeze bit reads 0.
- R2: Offset 0x10 returns the count zero-extended to 32 bits and ignores writes. Any unmapped offset reads 0.
- R3: Offset 0x14 holds the divider setting. Bits 7:0 are the denominator minus one and bits 15:8 are the numerator minus one. The setting reads back, and bits above 15 read 0.
- R4: Bit 0 of offset 0x4c is the freeze bit, and it reads back as written.
- R5: With a whole-number setting (numerator 1), a tick appears every denominator cycles: 0x000b gives one tick per 12 cycles, 0x000c one per 13 cycles and 0x0019 one per 26 cycles.
- R6: The setting 0x045f gives exactly 5 ticks in every 96 consecutive cycles, spaced 19 or 20 cycles apart.
- R7: The count changes only by +1, and it advances exactly once for each unfrozen tick.
- R8: The count wraps modulo 2^CNT_W.
- R9: From the second cycle with freeze set, no tick is issued and the count holds its value. After freeze is cleared, ticking resumes at the programmed rate.
- R10: A write to the divider setting clears the accumulator. With numerator 1 and denominator D, the first tick is visible in the cycle after the D-th clock edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| usec_tick | output | 1 | One-cycle microsecond tick |

## Verification
The bench builds two copies of the block. The first uses the default 32-bit count, where tick spacing, window totals, freeze and divider restart are measured for all four supported reference settings. The second is built with CNT_W = 8 and the setting 0x0000, which ticks on every cycle. With that instance the counter wrap is reached within a few hundred cycles instead of about 71 minutes of simulated time.

// File: rtl/usec_timebase_pkg.sv
// Shared constants and types for the microsecond timebase.
// Assumes byte offsets on the register port and an 8-bit divider field width.
package usec_timebase_pkg;
    localparam int FRAC_W    = 8;
    localparam int OFS_COUNT = 'h10;
    localparam int OFS_CFG   = 'h14;
    localparam int OFS_HOLD  = 'h4c;

    typedef struct packed {
        logic [FRAC_W-1:0] num_m1;
        logic [FRAC_W-1:0] den_m1;
    } div_cfg_t;
endpackage

// File: rtl/usec_regs.sv
// Register file for the timebase: divider setting, freeze bit and read mux.
// Assumes CNT_W <= DATA_W and 2*FRAC_W <= DATA_W; reads are combinational.
module usec_regs
    import usec_timebase_pkg::*;
#(
    parameter int       ADDR_W  = 8,
    parameter int       DATA_W  = 32,
    parameter int       CNT_W   = 32,
    parameter div_cfg_t RST_CFG = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic [FRAC_W-1:0] num_m1,
    output logic [FRAC_W-1:0] den_m1,
    output logic              freeze,
    output logic              cfg_wr
);
    localparam int CFG_W = 2 * FRAC_W;

    div_cfg_t cfg_q;
    logic     freeze_q;
    logic     unused_wdata;

    assign unused_wdata = &{1'b0, wdata[DATA_W-1:CFG_W]};
    assign cfg_wr = we && (addr == ADDR_W'(OFS_CFG));
    assign num_m1 = cfg_q.num_m1;
    assign den_m1 = cfg_q.den_m1;
    assign freeze = freeze_q;

    // Capture writes to the divider setting and the freeze bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= RST_CFG;
            freeze_q <= 1'b0;
        end else if (we) begin
            if (addr == ADDR_W'(OFS_CFG))  cfg_q    <= wdata[CFG_W-1:0];
            if (addr == ADDR_W'(OFS_HOLD)) freeze_q <= wdata[0];
        end
    end

    // Select read data by offset; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_COUNT))     rdata[CNT_W-1:0] = count;
        else if (addr == ADDR_W'(OFS_CFG))  rdata[CFG_W-1:0] = cfg_q;
        else if (addr == ADDR_W'(OFS_HOLD)) rdata[0]         = freeze_q;
    end
endmodule

// File: rtl/usec_frac_div.sv
// Fractional tick divider: adds the numerator each cycle, ticks and subtracts
// the denominator when the sum reaches it. Assumes numerator <= denominator.
module usec_frac_div #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] num_m1,
    input  logic [FRAC_W-1:0] den_m1,
    input  logic              restart,
    input  logic              hold,
    output logic              tick
);
    localparam int ACC_W = FRAC_W + 2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] num;
    logic [ACC_W-1:0] den;
    logic [ACC_W-1:0] sum;
    logic             tick_q;

    assign num  = ACC_W'(num_m1) + 1'b1;
    assign den  = ACC_W'(den_m1) + 1'b1;
    assign sum  = acc_q + num;
    assign tick = tick_q;

    // Advance the accumulator and register the tick decision.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (hold) begin
            tick_q <= 1'b0;
        end else if (sum >= den) begin
            acc_q  <= sum - den;
            tick_q <= 1'b1;
        end else begin
            acc_q  <= sum;
            tick_q <= 1'b0;
        end
    end
endmodule

// File: rtl/usec_counter.sv
// Free-running microsecond count, advanced by one per unfrozen tick.
// Assumes the tick is a single-cycle pulse; wraps at 2^CNT_W.
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    assign count = count_q;

    // Increment on each tick unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '0;
        else if (tick && !hold)  count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/usec_timebase.sv
// Top of the microsecond timebase: register port, fractional divider, counter.
// Assumes clk is the reference clock and the port runs in the same domain.
module usec_timebase
    import usec_timebase_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              usec_tick
);
    logic [FRAC_W-1:0] cfg_num_m1;
    logic [FRAC_W-1:0] cfg_den_m1;
    logic              freeze_q;
    logic              cfg_wr;
    logic [CNT_W-1:0]  count_q;

    usec_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .count  (count_q),
        .rdata  (bus_rdata),
        .num_m1 (cfg_num_m1),
        .den_m1 (cfg_den_m1),
        .freeze (freeze_q),
        .cfg_wr (cfg_wr)
    );

    usec_frac_div #(
        .FRAC_W (FRAC_W)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .num_m1  (cfg_num_m1),
        .den_m1  (cfg_den_m1),
        .restart (cfg_wr),
        .hold    (freeze_q),
        .tick    (usec_tick)
    );

    usec_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (usec_tick),
        .hold  (freeze_q),
        .count (count_q)
    );
endmodule

// File: rtl/usec_timebase_chk.sv
// Property checker for the timebase, attached to every instance by bind.
// Assumes synchronous active-low reset on the same clock.
module usec_timebase_chk #(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usec_tick,
    input logic              freeze,
    input logic [CNT_W-1:0]  count,
    input logic [FRAC_W-1:0] num_m1,
    input logic [FRAC_W-1:0] den_m1
);
    logic              sparse;
    logic [FRAC_W+1:0] num2;
    logic [FRAC_W+1:0] den;

    assign num2   = ({2'b00, num_m1} + 1'b1) << 1;
    assign den    = {2'b00, den_m1} + 1'b1;
    assign sparse = (num2 <= den);

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && $past(freeze) |-> !usec_tick);                          // R9
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(count));                                       // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> count == CNT_W'($past(count) + 1'b1));        // R7
    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(usec_tick) && !$past(freeze) |-> !$stable(count));          // R7
    AST_SPARSE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sparse && $stable(num_m1) && $stable(den_m1) && $past(usec_tick)
            |-> !usec_tick);                                              // R5
endmodule

bind usec_timebase usec_timebase_chk #(
    .CNT_W  (CNT_W),
    .FRAC_W (usec_timebase_pkg::FRAC_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .usec_tick (usec_tick),
    .freeze    (freeze_q),
    .count     (count_q),
    .num_m1    (cfg_num_m1),
    .den_m1    (cfg_den_m1)
);

// File: tb/test_usec_timebase.sv
`timescale 1ns/100ps
module test_usec_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0, s_addr = '0;
    logic [31:0] bus_wdata = '0, s_wdata = '0;
    logic        bus_we = 1'b0, s_we = 1'b0;
    logic [31:0] bus_rdata, s_rdata;
    logic        usec_tick, s_tick;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    usec_timebase i_usec_timebase (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .usec_tick(usec_tick));

    usec_timebase #(.CNT_W(8)) i_usec_timebase_w8 (
        .clk(clk), .rst_n(rst_n), .bus_addr(s_addr), .bus_wdata(s_wdata),
        .bus_we(s_we), .bus_rdata(s_rdata), .usec_tick(s_tick));

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(bit sel, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        if (sel) begin s_addr = a; s_wdata = d; s_we = 1'b1; end
        else begin bus_addr = a; bus_wdata = d; bus_we = 1'b1; end
        @(negedge clk);
        s_we = 1'b0;
        bus_we = 1'b0;
    endtask

    // Read combinationally without consuming a clock edge.
    task automatic rd(bit sel, logic [7:0] a, output logic [31:0] d);
        if (sel) begin s_addr = a; #1; d = s_rdata; end
        else begin bus_addr = a; #1; d = bus_rdata; end
    endtask

    // Observe L cycles: tick total, gap extremes, count advance.
    task automatic measure(int L, output int ticks, output int gmin,
                           output int gmax, output logic [31:0] delta);
        logic [31:0] c0, c1;
        int last = -1;
        ticks = 0; gmin = 1 << 30; gmax = 0;
        rd(1'b0, 8'h10, c0);
        for (int i = 1; i <= L; i++) begin
            @(negedge clk);
            if (usec_tick) begin
                ticks++;
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
        end
        rd(1'b0, 8'h10, c1);
        delta = c1 - c0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, 8'h10, v); chk("R1", "count after reset", v, 0);
        rd(1'b0, 8'h14, v); chk("R1", "setting after reset", v, 32'h000b);
        rd(1'b0, 8'h4c, v); chk("R1", "freeze after reset", v, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(1'b0, 8'h14, 32'hFFFF_045F);
        rd(1'b0, 8'h14, v); chk("R3", "setting readback, upper bits zero", v, 32'h045f);
        rd(1'b0, 8'h20, v); chk("R2", "unmapped offset", v, 0);
        wr(1'b0, 8'h14, 32'h000b);
    endtask

    task automatic t_integer(logic [31:0] setting, int d);
        int t, gmin, gmax;
        logic [31:0] dl;
        wr(1'b0, 8'h14, setting);
        repeat (3) @(negedge clk);
        measure(10 * d, t, gmin, gmax, dl);
        chk("R5", $sformatf("ticks per %0d cycles", 10 * d), t, 10);
        chk("R5", "minimum gap", gmin, d);
        chk("R5", "maximum gap", gmax, d);
        chk("R7", "count advance equals ticks", dl, 10);
    endtask

    task automatic t_frac;
        int t, gmin, gmax;
        logic [31:0] dl;
        wr(1'b0, 8'h14, 32'h045f);
        repeat (7) @(negedge clk);
        measure(960, t, gmin, gmax, dl);
        chk("R6", "ticks in 960 cycles", t, 50);
        chk("R6", "minimum gap", gmin, 19);
        chk("R6", "maximum gap", gmax, 20);
        chk("R7", "count advance in 960 cycles", dl, 50);
    endtask

    task automatic t_restart;
        int early = 0;
        wr(1'b0, 8'h14, 32'h0019);
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            if (usec_tick) early++;
        end
        chk("R10", "ticks before 26th edge", early, 0);
        @(negedge clk);
        chk("R10", "tick after 26th edge", usec_tick, 1);
    endtask

    task automatic t_freeze;
        logic [31:0] c0, c1, v, dl;
        int stray = 0, t, gmin, gmax;
        wr(1'b0, 8'h14, 32'h000b);
        repeat (5) @(negedge clk);
        wr(1'b0, 8'h4c, 32'h1);
        @(negedge clk);
        rd(1'b0, 8'h10, c0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (usec_tick) stray++;
        end
        chk("R9", "ticks while frozen", stray, 0);
        rd(1'b0, 8'h10, c1); chk("R9", "count held while frozen", c1, c0);
        rd(1'b0, 8'h4c, v); chk("R4", "freeze readback", v, 1);
        wr(1'b0, 8'h10, 32'hDEAD_BEEF);
        rd(1'b0, 8'h10, v); chk("R2", "count write ignored", v, c0);
        wr(1'b0, 8'h4c, 32'h0);
        rd(1'b0, 8'h4c, v); chk("R4", "freeze cleared readback", v, 0);
        measure(120, t, gmin, gmax, dl);
        chk("R9", "ticks after unfreeze", t, 10);
        chk("R9", "count resumes", dl, 10);
    endtask

    task automatic t_wrap;
        logic [31:0] c0, c1;
        wr(1'b1, 8'h14, 32'h0000);
        repeat (3) @(negedge clk);
        rd(1'b1, 8'h10, c0);
        repeat (300) @(negedge clk);
        rd(1'b1, 8'h10, c1);
        chk("R8", "8-bit count wraps", c1, (c0 + 300) & 32'hff);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_integer(32'h000b, 12);
        t_integer(32'h000c, 13);
        t_integer(32'h0019, 26);
        t_frac();
        t_restart();
        t_freeze();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule